// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out a multi-register load or store for a 32-bit processor core. A start pulse hands it the instruction word, five mode flags (pre-step, upward, user bank, writeback, load) and the current base register value. The block then steps through the 16-bit register list held in the instruction. For every selected register it issues one word access on a simple valid/ready memory port. On a store it reads the register file. On a load it writes the register file.

The register selection order and the address stepping both follow the flags. The block applies the program-counter adjustments: an offset on a store and word alignment on a load. It chooses between the current bank and the user bank, and it requests a status-register restore when the flags call for one. When the walk is over it pulses done. It presents the final address together with a writeback strobe and the base register index, so the core can update the base.

Top module: `blkxfer_seq`

## Requirements
- R1: A start pulse while idle latches the operands and raises busy. Busy holds until the cycle after done. Done is high for exactly one cycle, in the cycle after the last accepted access.
- R2: The register list is instruction bits 15:0, where bit i selects register i. The base register index is bits 19:16. With upward set, registers are visited in ascending order. With upward clear, they are visited in descending order.
- R3: Each visited register moves the address by 4: up when upward is set, down when it is clear. With pre-step set the move happens before the access; with it clear the move happens after.
- R4: An access holds bus_valid with a stable address, direction and data until bus_ready is seen. Only then does the block move on.
- R5: With writeback set, wb_en pulses together with done. At that point final_addr carries the address after the last step and wb_idx carries the base index.
- R6: On a load whose list contains the base register, wb_en stays low even with writeback set. On a store, writeback happens either way.
- R7: A store of register 15 writes the register-file value plus 8 to memory.
- R8: A load into register 15 writes the loaded word with bits 1:0 cleared.
- R9: On a load with user bank set and register 15 absent from the list, every register-file write has rf_wr_user high.
- R10: On a load with user bank set and register 15 in the list, writes go to the current bank (rf_wr_user low). psr_restore pulses in the same cycle as the register 15 write.
- R11: On a store with user bank set, every register-file read has rf_rd_user high, whether or not register 15 is listed.
- R12: An empty list produces no bus access. Done follows one cycle after start, and final_addr equals the base value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (honoured when idle) |
| instr | input | 32 | Instruction word: list and base index |
| flag_pre | input | 1 | Step address before each access |
| flag_up | input | 1 | Ascending order, increasing address |
| flag_usr | input | 1 | User-bank transfer request |
| flag_wb | input | 1 | Write final address back to base |
| flag_load | input | 1 | 1 = load, 0 = store |
| base_val | input | 32 | Base register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_valid | output | 1 | Memory access request |
| bus_we | output | 1 | Memory write enable |
| bus_addr | output | 32 | Memory word address |
| bus_wdata | output | 32 | Store data |
| bus_ready | input | 1 | Memory accepts the access |
| bus_rdata | input | 32 | Load data, valid with bus_ready |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_user | output | 1 | Read from user bank |
| rf_rd_data | input | 32 | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_user | output | 1 | Write to user bank |
| rf_wr_data | output | 32 | Register-file write data |
| psr_restore | output | 1 | Restore status register from saved copy |
| wb_en | output | 1 | Base writeback strobe |
| wb_idx | output | 4 | Base register index |
| final_addr | output | 32 | Address after the last step |

## Verification
Two effects can occur in the same cycle: the register 15 write on a user-bank load and the status-restore request. The bench provokes this with user-bank loads that include register 15, in both directions and under memory stalls. The scoreboard attaches the expected restore flag to each predicted access. It then judges psr_restore, rf_wr_user and the aligned data at the same accepted handshake. A second pairing is the load of the base register and the writeback decision taken at done; this is judged by comparing wb_en against the prediction for lists that include and exclude the base.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef struct packed {
        logic pre;
        logic up;
        logic usr;
        logic wb;
        logic load;
    } xfer_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } xfer_state_t;

    localparam int WORD_STEP = 4;
    localparam int PC_OFFSET = 8;

endpackage

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask,
    input  logic            up,
    output logic [IW-1:0]   idx
);
    logic [IW-1:0] lo_idx;
    logic [IW-1:0] hi_idx;

    always_comb begin
        lo_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i]) lo_idx = IW'(i);
        end
    end

    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (mask[i]) hi_idx = IW'(i);
        end
    end

    assign idx = up ? lo_idx : hi_idx;
endmodule

// File: rtl/blkxfer_addr.sv
module blkxfer_addr #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cur,
    input  logic          pre,
    input  logic          up,
    output logic [DW-1:0] acc,
    output logic [DW-1:0] nxt
);
    import blkxfer_pkg::*;
    localparam logic [DW-1:0] STEP = DW'(WORD_STEP);

    assign nxt = up ? cur + STEP : cur - STEP;
    assign acc = pre ? nxt : cur;
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [31:0]   instr,
    input  logic          flag_pre,
    input  logic          flag_up,
    input  logic          flag_usr,
    input  logic          flag_wb,
    input  logic          flag_load,
    input  logic [DW-1:0] base_val,
    output logic          busy,
    output logic          done,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [DW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic [IW-1:0] rf_rd_idx,
    output logic          rf_rd_user,
    input  logic [DW-1:0] rf_rd_data,
    output logic          rf_wr_en,
    output logic [IW-1:0] rf_wr_idx,
    output logic          rf_wr_user,
    output logic [DW-1:0] rf_wr_data,
    output logic          psr_restore,
    output logic          wb_en,
    output logic [IW-1:0] wb_idx,
    output logic [DW-1:0] final_addr
);
    import blkxfer_pkg::*;

    localparam logic [IW-1:0]   PC_IDX  = IW'(NREG - 1);
    localparam logic [DW-1:0]   PC_ADD  = DW'(PC_OFFSET);
    localparam logic [DW-1:0]   ALIGN_M = ~DW'(WORD_STEP - 1);
    localparam int              BASE_LO = NREG;

    xfer_state_t   st_q;
    xfer_flags_t   fl_q;
    logic [NREG-1:0] left_q;
    logic [IW-1:0]   bidx_q;
    logic [DW-1:0]   addr_q;
    logic            pc_in_q;
    logic            base_in_q;

    logic [IW-1:0]   cur_idx;
    logic [DW-1:0]   acc_addr;
    logic [DW-1:0]   nxt_addr;
    logic            hs;
    logic            cur_is_pc;
    logic [NREG-1:0] left_nxt;

    logic [NREG-1:0] in_list;
    logic [IW-1:0]   in_bidx;
    assign in_list = instr[NREG-1:0];
    assign in_bidx = instr[BASE_LO+IW-1:BASE_LO];

    blkxfer_pick #(.NREG(NREG)) u_pick (
        .mask (left_q),
        .up   (fl_q.up),
        .idx  (cur_idx)
    );

    blkxfer_addr #(.DW(DW)) u_addr (
        .cur  (addr_q),
        .pre  (fl_q.pre),
        .up   (fl_q.up),
        .acc  (acc_addr),
        .nxt  (nxt_addr)
    );

    assign cur_is_pc = (cur_idx == PC_IDX);
    assign hs        = (st_q == ST_RUN) && bus_ready;
    assign left_nxt  = left_q & ~(NREG'(1) << cur_idx);

    // bus side
    assign bus_valid  = (st_q == ST_RUN);
    assign bus_we     = !fl_q.load;
    assign bus_addr   = acc_addr;
    assign rf_rd_idx  = cur_idx;
    assign rf_rd_user = fl_q.usr;
    assign bus_wdata  = cur_is_pc ? rf_rd_data + PC_ADD : rf_rd_data;

    // register-file write side
    assign rf_wr_en    = hs && fl_q.load;
    assign rf_wr_idx   = cur_idx;
    assign rf_wr_user  = fl_q.usr && !pc_in_q;
    assign rf_wr_data  = cur_is_pc ? (bus_rdata & ALIGN_M) : bus_rdata;
    assign psr_restore = hs && fl_q.load && fl_q.usr && pc_in_q && cur_is_pc;

    // completion
    assign busy       = (st_q != ST_IDLE);
    assign done       = (st_q == ST_FIN);
    assign wb_en      = done && fl_q.wb && !(fl_q.load && base_in_q);
    assign wb_idx     = bidx_q;
    assign final_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            fl_q      <= '0;
            left_q    <= '0;
            bidx_q    <= '0;
            addr_q    <= '0;
            pc_in_q   <= 1'b0;
            base_in_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        fl_q      <= '{pre: flag_pre, up: flag_up, usr: flag_usr,
                                       wb: flag_wb, load: flag_load};
                        left_q    <= in_list;
                        bidx_q    <= in_bidx;
                        addr_q    <= base_val;
                        pc_in_q   <= in_list[NREG-1];
                        base_in_q <= in_list[in_bidx];
                        st_q      <= (in_list == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (hs) begin
                        left_q <= left_nxt;
                        addr_q <= nxt_addr;
                        if (left_nxt == '0) st_q <= ST_FIN;
                    end
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          bus_valid,
    input logic          bus_we,
    input logic          bus_ready,
    input logic [DW-1:0] bus_addr,
    input logic          rf_wr_en,
    input logic [IW-1:0] rf_wr_idx,
    input logic          rf_wr_user,
    input logic [DW-1:0] rf_wr_data,
    input logic          psr_restore,
    input logic          wb_en
);
    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

    a_r1_valid_in_busy: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> busy);

    a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_word_step: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready) |=>
        (!bus_valid || bus_addr == $past(bus_addr) + DW'(4) || bus_addr == $past(bus_addr) - DW'(4)));

    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)));

    a_r5_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    a_r8_pc_aligned: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en && rf_wr_idx == PC_IDX) |-> (rf_wr_data[1:0] == 2'b00));

    a_r10_restore_with_pc: assert property (@(posedge clk) disable iff (rst)
        psr_restore |-> (rf_wr_en && rf_wr_idx == PC_IDX && !rf_wr_user));
endmodule

bind blkxfer_seq blkxfer_chk #(.NREG(NREG), .DW(DW)) u_chk (.*);

// File: tb/sim_blkxfer_seq.sv
module sim_blkxfer_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        flag_pre = 0, flag_up = 0, flag_usr = 0, flag_wb = 0, flag_load = 0;
    logic [31:0] base_val = '0;
    logic        busy, done, bus_valid, bus_we;
    logic [31:0] bus_addr, bus_wdata, bus_rdata, rf_rd_data, rf_wr_data, final_addr;
    logic        bus_ready = 1'b0;
    logic [3:0]  rf_rd_idx, rf_wr_idx, wb_idx;
    logic        rf_rd_user, rf_wr_en, rf_wr_user, psr_restore, wb_en;

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit stall_on = 0;

    function automatic logic [31:0] rf_model(logic [3:0] idx, logic usr);
        return usr ? {16'hA5A5, 12'h000, idx} : {16'h3C3C, 12'h000, idx};
    endfunction

    function automatic logic [31:0] mem_model(logic [31:0] a);
        return a ^ 32'h0F0F_F0F3;
    endfunction

    assign rf_rd_data = rf_model(rf_rd_idx, rf_rd_user);
    assign bus_rdata  = mem_model(bus_addr);

    blkxfer_seq u0 (.*);

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  idx;
        logic        user;
        logic        rest;
    } acc_t;

    typedef struct {
        logic [31:0] fin;
        logic        wb;
        logic [3:0]  bidx;
    } fin_t;

    acc_t acc_q[$];
    fin_t fin_q[$];

    task automatic check(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    // ready pattern: driven just after each rising edge
    initial begin
        int c = 0;
        forever begin
            @(posedge clk);
            #1;
            c++;
            bus_ready <= stall_on ? ((c % 3) != 1) : 1'b1;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_valid && bus_ready) begin
                if (acc_q.size() == 0) begin
                    check(0, "R12", "unexpected access addr", bus_addr, 32'h0);
                end else begin
                    acc_t e;
                    e = acc_q.pop_front();
                    check(bus_addr == e.addr, "R3", "addr", bus_addr, e.addr);
                    check(bus_we == e.we, "R2", "direction", {31'b0, bus_we}, {31'b0, e.we});
                    if (e.we) begin
                        check(rf_rd_idx == e.idx, "R2", "read order", {28'b0, rf_rd_idx}, {28'b0, e.idx});
                        check(rf_rd_user == e.user, "R11", "read bank", {31'b0, rf_rd_user}, {31'b0, e.user});
                        check(bus_wdata == e.data, "R7", "store data", bus_wdata, e.data);
                        check(!rf_wr_en, "R2", "no rf write on store", {31'b0, rf_wr_en}, 32'h0);
                    end else begin
                        check(rf_wr_en && rf_wr_idx == e.idx, "R2", "write order", {27'b0, rf_wr_en, rf_wr_idx}, {27'b1, e.idx});
                        check(rf_wr_user == e.user, "R9", "write bank", {31'b0, rf_wr_user}, {31'b0, e.user});
                        check(rf_wr_data == e.data, "R8", "load data", rf_wr_data, e.data);
                    end
                    check(psr_restore == e.rest, "R10", "restore", {31'b0, psr_restore}, {31'b0, e.rest});
                end
            end
            if (done) begin
                if (fin_q.size() == 0) begin
                    check(0, "R1", "unexpected done", 32'h1, 32'h0);
                end else begin
                    fin_t f;
                    f = fin_q.pop_front();
                    check(acc_q.size() == 0, "R1", "accesses left at done", acc_q.size(), 0);
                    check(final_addr == f.fin, "R5", "final addr", final_addr, f.fin);
                    check(wb_en == f.wb, "R6", "wb strobe", {31'b0, wb_en}, {31'b0, f.wb});
                    check(wb_idx == f.bidx, "R5", "wb index", {28'b0, wb_idx}, {28'b0, f.bidx});
                end
            end
        end
    end

    task automatic run_op(bit pre, bit up, bit usr, bit wb, bit ld,
                          logic [3:0] rn, logic [15:0] list, logic [31:0] base);
        logic [31:0] a = base;
        int waitc = 0;
        fin_t f;
        for (int k = 0; k < 16; k++) begin
            int i = up ? k : 15 - k;
            if (list[i]) begin
                acc_t e;
                if (pre) a = up ? a + 4 : a - 4;
                e.we   = !ld;
                e.addr = a;
                e.idx  = 4'(i);
                if (ld) begin
                    e.user = usr && !list[15];
                    e.data = (i == 15) ? (mem_model(a) & 32'hFFFF_FFFC) : mem_model(a);
                    e.rest = usr && list[15] && (i == 15);
                end else begin
                    e.user = usr;
                    e.data = rf_model(4'(i), usr) + ((i == 15) ? 32'd8 : 32'd0);
                    e.rest = 1'b0;
                end
                acc_q.push_back(e);
                if (!pre) a = up ? a + 4 : a - 4;
            end
        end
        f.fin  = a;
        f.wb   = wb && !(ld && list[rn]);
        f.bidx = rn;
        fin_q.push_back(f);

        @(posedge clk); #1;
        start <= 1'b1;
        instr <= {12'h0E8, rn, list};
        flag_pre <= pre; flag_up <= up; flag_usr <= usr; flag_wb <= wb; flag_load <= ld;
        base_val <= base;
        @(posedge clk); #1;
        start <= 1'b0;
        instr <= 32'hFFFF_FFFF;
        @(negedge clk);
        check(busy, "R1", "busy after start", {31'b0, busy}, 32'h1);
        if (list == 16'h0)
            check(done, "R12", "empty list done next cycle", {31'b0, done}, 32'h1);
        while (!done && waitc < 500) begin
            @(negedge clk);
            waitc++;
        end
        @(negedge clk);
        check(!busy && !done, "R1", "idle after done", {30'b0, busy, done}, 32'h0);
    endtask

    bit finished = 0;

    initial begin
        repeat (4) @(posedge clk);
        #1 rst <= 1'b0;
        @(negedge clk);
        check(!busy && !done && !bus_valid && !wb_en, "R1", "reset state",
              {28'b0, busy, done, bus_valid, wb_en}, 32'h0);

        // R2 R3 R7: ascending post-step store, incl. r15
        run_op(0, 1, 0, 1, 0, 4'd2, 16'h80F1, 32'h0000_1000);
        // R2 R3 R8: descending pre-step load incl. r15, no user
        run_op(1, 0, 0, 1, 1, 4'd13, 16'h8421, 32'h0000_2000);
        // R9: user-bank load without r15
        run_op(1, 1, 1, 1, 1, 4'd0, 16'h0E0C, 32'h0000_3000);
        // R10: user-bank load with r15, descending post-step
        run_op(0, 0, 1, 0, 1, 4'd1, 16'hC003, 32'h0000_4000);
        // R11: user-bank store with r15
        run_op(1, 0, 1, 1, 0, 4'd3, 16'h8006, 32'h0000_5000);
        // R6: load containing base with writeback -> suppressed
        run_op(0, 1, 0, 1, 1, 4'd5, 16'h0031, 32'h0000_6000);
        // R6: store containing base with writeback -> performed
        run_op(0, 1, 0, 1, 0, 4'd5, 16'h0031, 32'h0000_7000);
        // R12: empty list
        run_op(1, 1, 0, 1, 0, 4'd7, 16'h0000, 32'h0000_8000);
        run_op(0, 0, 0, 1, 1, 4'd7, 16'h0000, 32'h0000_8800);
        // R4: stalls on full list, both directions
        stall_on = 1;
        run_op(0, 1, 0, 1, 0, 4'd9, 16'hFFFF, 32'h0001_0000);
        run_op(1, 0, 1, 1, 1, 4'd9, 16'hFFFF, 32'h0002_0000);
        run_op(1, 1, 1, 0, 1, 4'd4, 16'h8010, 32'h0000_0010);
        stall_on = 0;
        // address wrap downward
        run_op(1, 0, 0, 1, 0, 4'd0, 16'h0006, 32'h0000_0004);

        repeat (3) @(negedge clk);
        check(acc_q.size() == 0 && fin_q.size() == 0, "R1", "queues drained",
              acc_q.size() + fin_q.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog got %h exp %h", 32'h0, 32'h1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule